// File: doc/BRIEF.md
# Paged Program Counter Unit

This unit produces the 12-bit instruction ROM address of a small 4-bit processor. The address is made of two parts held in separate registers. The top bit is a page select. The lower 11 bits form a counter that steps by one. In every clock cycle the sequencer supplies an operation code. The unit then either advances the counter or loads a new address. The new address can be a jump target, a taken-branch target, a subroutine entry, an interrupt vector or a return address.

Only an unconditional jump can change the page bit. Every other load replaces the low 11 bits and leaves the page as it was. The counter wraps inside its own 11 bits and never carries into the page. At the same time, the unit presents the 11-bit address of the following instruction, which the caller's stack stores on a call or interrupt.

Internally, a small state machine records what kind of update produced the address now held:
- ST_BOOT: in reset.
- ST_SEQ: sequential step.
- ST_LOAD_FAR: jump that also loads the page.
- ST_LOAD_NEAR: load of the low bits only.

Transitions:
- Reset enters ST_BOOT from any state.
- Op code 0 or 6 or 7 moves to ST_SEQ.
- Op code 1 moves to ST_LOAD_FAR.
- Op codes 2 to 5 move to ST_LOAD_NEAR.

The address registers update on the same edge as that transition.

Top module: `pc_unit`

## Requirements
- R1: While rst_n is low, and on the first sample after it, rom_addr is 12'h000.
- R2: Op code 0 (step) makes rom_addr[10:0] one greater on the next clock edge, and rom_addr[11] keeps its value.
- R3: A step from low bits 11'h7FF gives low bits 11'h000, and rom_addr[11] is not changed.
- R4: Op code 1 (jump) loads rom_addr with {page_in, tgt_addr} on the next edge.
- R5: Op code 2 (taken branch) loads tgt_addr into the low bits, and page_in is ignored.
- R6: Op code 3 (call) loads tgt_addr into the low bits, and the page bit is kept.
- R7: Op code 4 (interrupt) loads int_vec into the low bits, and the page bit is kept.
- R8: Op code 5 (return) loads ret_addr into the low bits, and the page bit is kept.
- R9: The spare op codes 6 and 7 behave exactly like a step.
- R10: push_addr always equals rom_addr[10:0] plus one, modulo 2^11, in the same cycle. It needs no clock edge.
- R11: A low rst_n overrides any op code and forces the address to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_op | input | 3 | Next-address operation code |
| tgt_addr | input | 11 | Jump, branch or call target |
| page_in | input | 1 | Page value used by a jump |
| int_vec | input | 11 | Interrupt entry address |
| ret_addr | input | 11 | Address popped from the stack |
| rom_addr | output | 12 | Current ROM address {page, counter} |
| push_addr | output | 11 | Return address to save on call or interrupt |

## Verification
Every address update is due one rising edge after its operation code is applied. The bench drives inputs on a falling edge and compares rom_addr on the next falling edge, with exactly one register in between. push_addr is combinational from the current address. It is therefore checked in the same half-cycle in which the inputs are driven, before the edge that consumes them. Reset is checked both while it is asserted together with a jump code, and again after it is released in the middle of a run.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;

    typedef enum logic [2:0] {
        OP_STEP   = 3'd0,
        OP_JUMP   = 3'd1,
        OP_BRANCH = 3'd2,
        OP_CALL   = 3'd3,
        OP_IRQ    = 3'd4,
        OP_RETURN = 3'd5
    } pc_op_e;

    typedef enum logic [1:0] {
        ST_BOOT      = 2'd0,
        ST_SEQ       = 2'd1,
        ST_LOAD_FAR  = 2'd2,
        ST_LOAD_NEAR = 2'd3
    } pc_state_e;

endpackage

// File: rtl/pc_ripple_inc.sv
module pc_ripple_inc #(
    parameter int W = 11
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);

    logic [W-1:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = a[i] ^ carry[i];
        if (i < W - 1) begin : g_chain
            assign carry[i+1] = a[i] & carry[i];
        end
    end

endmodule

// File: rtl/pc_near_sel.sv
module pc_near_sel
    import pc_unit_pkg::*;
#(
    parameter int W = 11
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] tgt,
    input  logic [W-1:0] vec,
    input  logic [W-1:0] ret,
    output logic [W-1:0] near_low
);

    always_comb begin
        case (pc_op_e'(op))
            OP_BRANCH: near_low = tgt;
            OP_CALL:   near_low = tgt;
            OP_IRQ:    near_low = vec;
            OP_RETURN: near_low = ret;
            default:   near_low = tgt;
        endcase
    end

endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import pc_unit_pkg::*;
#(
    parameter int LOW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       ctl_op,
    input  logic [LOW_W-1:0] tgt_addr,
    input  logic             page_in,
    input  logic [LOW_W-1:0] int_vec,
    input  logic [LOW_W-1:0] ret_addr,
    output logic [LOW_W:0]   rom_addr,
    output logic [LOW_W-1:0] push_addr
);

    localparam int ADDR_W = LOW_W + 1;

    pc_state_e        state_q;
    pc_state_e        state_nxt;
    logic [LOW_W-1:0] low_q;
    logic             page_q;
    logic [LOW_W-1:0] low_inc;
    logic [LOW_W-1:0] near_low;

    pc_ripple_inc #(.W(LOW_W)) i_inc (
        .a (low_q),
        .y (low_inc)
    );

    pc_near_sel #(.W(LOW_W)) i_near (
        .op       (ctl_op),
        .tgt      (tgt_addr),
        .vec      (int_vec),
        .ret      (ret_addr),
        .near_low (near_low)
    );

    always_comb begin
        case (pc_op_e'(ctl_op))
            OP_STEP:   state_nxt = ST_SEQ;
            OP_JUMP:   state_nxt = ST_LOAD_FAR;
            OP_BRANCH,
            OP_CALL,
            OP_IRQ,
            OP_RETURN: state_nxt = ST_LOAD_NEAR;
            default:   state_nxt = ST_SEQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q  <= '0;
            page_q <= 1'b0;
        end else begin
            unique case (state_nxt)
                ST_SEQ: begin
                    low_q <= low_inc;
                end
                ST_LOAD_FAR: begin
                    low_q  <= tgt_addr;
                    page_q <= page_in;
                end
                ST_LOAD_NEAR: begin
                    low_q <= near_low;
                end
                ST_BOOT: begin
                    low_q  <= '0;
                    page_q <= 1'b0;
                end
            endcase
        end
    end

    assign rom_addr  = ADDR_W'({page_q, low_q});
    assign push_addr = low_inc;

endmodule

// File: rtl/pc_unit_chk.sv
module pc_unit_chk
    import pc_unit_pkg::*;
#(
    parameter int LOW_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       ctl_op,
    input logic [LOW_W-1:0] tgt_addr,
    input logic             page_in,
    input logic [LOW_W-1:0] int_vec,
    input logic [LOW_W-1:0] ret_addr,
    input logic [LOW_W:0]   rom_addr,
    input logic [LOW_W-1:0] push_addr,
    input pc_state_e        state_q
);

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> rom_addr == '0); // R1

    AST_BOOT_ORIGIN: assert property (@(posedge clk)
        state_q == ST_BOOT |-> rom_addr == '0); // R11

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_op == 3'd0 |=> rom_addr[LOW_W-1:0] == LOW_W'($past(rom_addr[LOW_W-1:0]) + 1'b1)
                           && rom_addr[LOW_W] == $past(rom_addr[LOW_W])); // R2

    AST_WRAP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_op == 3'd0 && rom_addr[LOW_W-1:0] == '1) |=> rom_addr[LOW_W-1:0] == '0
                           && $stable(rom_addr[LOW_W])); // R3

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_op == 3'd1 |=> rom_addr == {$past(page_in), $past(tgt_addr)}); // R4

    AST_BRANCH_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_op == 3'd2 |=> rom_addr[LOW_W-1:0] == $past(tgt_addr) && $stable(rom_addr[LOW_W])); // R5

    AST_CALL_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_op == 3'd3 |=> rom_addr[LOW_W-1:0] == $past(tgt_addr) && $stable(rom_addr[LOW_W])); // R6

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_op == 3'd4 |=> rom_addr[LOW_W-1:0] == $past(int_vec) && $stable(rom_addr[LOW_W])); // R7

    AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_op == 3'd5 |=> rom_addr[LOW_W-1:0] == $past(ret_addr) && $stable(rom_addr[LOW_W])); // R8

    AST_SPARE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_op[2:1] == 2'b11 |=> rom_addr[LOW_W-1:0] == LOW_W'($past(rom_addr[LOW_W-1:0]) + 1'b1)
                                 && $stable(rom_addr[LOW_W])); // R9

    AST_PUSH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        push_addr == LOW_W'(rom_addr[LOW_W-1:0] + 1'b1)); // R10

endmodule

bind pc_unit pc_unit_chk #(.LOW_W(LOW_W)) i_pc_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_op    (ctl_op),
    .tgt_addr  (tgt_addr),
    .page_in   (page_in),
    .int_vec   (int_vec),
    .ret_addr  (ret_addr),
    .rom_addr  (rom_addr),
    .push_addr (push_addr),
    .state_q   (state_q)
);

// File: tb/test_pc_unit.sv
`timescale 1ns/1ps
module test_pc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ctl_op = 3'd0;
    logic [10:0] tgt_addr = '0;
    logic        page_in = 1'b0;
    logic [10:0] int_vec = '0;
    logic [10:0] ret_addr = '0;
    logic [11:0] rom_addr;
    logic [10:0] push_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pc_unit i_pc_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_op    (ctl_op),
        .tgt_addr  (tgt_addr),
        .page_in   (page_in),
        .int_vec   (int_vec),
        .ret_addr  (ret_addr),
        .rom_addr  (rom_addr),
        .push_addr (push_addr)
    );

    // {op, tgt, page, vec, ret, expected rom_addr after the edge}
    localparam int NVEC = 14;
    localparam logic [48:0] VEC [NVEC] = '{
        {3'd0, 11'h000, 1'b0, 11'h000, 11'h000, 12'h001}, // R2
        {3'd1, 11'h7FE, 1'b1, 11'h000, 11'h000, 12'hFFE}, // R4
        {3'd0, 11'h000, 1'b0, 11'h000, 11'h000, 12'hFFF}, // R2
        {3'd0, 11'h000, 1'b0, 11'h000, 11'h000, 12'h800}, // R3
        {3'd2, 11'h123, 1'b0, 11'h000, 11'h000, 12'h923}, // R5
        {3'd3, 11'h055, 1'b0, 11'h000, 11'h000, 12'h855}, // R6
        {3'd4, 11'h000, 1'b0, 11'h004, 11'h000, 12'h804}, // R7
        {3'd5, 11'h000, 1'b0, 11'h000, 11'h124, 12'h924}, // R8
        {3'd6, 11'h3FF, 1'b1, 11'h000, 11'h000, 12'h925}, // R9
        {3'd7, 11'h3FF, 1'b0, 11'h000, 11'h000, 12'h926}, // R9
        {3'd1, 11'h7FF, 1'b0, 11'h000, 11'h000, 12'h7FF}, // R4
        {3'd0, 11'h000, 1'b1, 11'h000, 11'h000, 12'h000}, // R3
        {3'd5, 11'h000, 1'b1, 11'h000, 11'h3AB, 12'h3AB}, // R8
        {3'd4, 11'h000, 1'b1, 11'h010, 11'h000, 12'h010}  // R7
    };

    function automatic string op_req(input logic [2:0] op, input logic [11:0] prev);
        case (op)
            3'd0:    return (prev[10:0] == 11'h7FF) ? "R3" : "R2";
            3'd1:    return "R4";
            3'd2:    return "R5";
            3'd3:    return "R6";
            3'd4:    return "R7";
            3'd5:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [10:0] t, input logic p,
                         input logic [10:0] v, input logic [10:0] r);
        ctl_op   = op;
        tgt_addr = t;
        page_in  = p;
        int_vec  = v;
        ret_addr = r;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] prev;
        // R1 / R11: reset holds zero even with a jump requested
        drive(3'd1, 11'h7FF, 1'b1, 11'h000, 11'h000);
        repeat (3) @(negedge clk);
        chk("R1", rom_addr, 12'h000);
        @(negedge clk);
        chk("R11", rom_addr, 12'h000);
        chk("R10", {1'b0, push_addr}, 12'h001);
        rst_n = 1'b1;
        prev = 12'h000;

        for (int i = 0; i < NVEC; i++) begin
            logic [48:0] v;
            v = VEC[i];
            drive(v[48:46], v[45:35], v[34], v[33:23], v[22:12]);
            #0.1;
            chk("R10", {1'b0, push_addr}, {1'b0, 11'(prev[10:0] + 11'd1)});
            @(negedge clk);
            chk(op_req(v[48:46], prev), rom_addr, v[11:0]);
            prev = v[11:0];
        end

        // R11: reset in the middle of a run, with a jump code applied
        drive(3'd1, 11'h555, 1'b1, 11'h000, 11'h000);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", rom_addr, 12'h000);
        rst_n = 1'b1;
        drive(3'd0, 11'h000, 1'b1, 11'h000, 11'h000);
        @(negedge clk);
        chk("R2", rom_addr, 12'h001);

        // R5: branch with page_in set must not alter the page
        drive(3'd2, 11'h7FF, 1'b1, 11'h000, 11'h000);
        @(negedge clk);
        chk("R5", rom_addr, 12'h7FF);
        // R10: push value wraps at the top of the counter
        chk("R10", {1'b0, push_addr}, 12'h000);
        // R3: step from 7FF stays on page 0
        drive(3'd0, 11'h000, 1'b1, 11'h000, 11'h000);
        @(negedge clk);
        chk("R3", rom_addr, 12'h000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule